// File: doc/BRIEF.md
# Byte-Wide SPI Port with Status Flags

This block is a byte-wide serial peripheral port that sits behind a small register interface. Three registers are visible on the bus: a control register, a status register, and a data register. Writing the data register loads a transmit buffer. Reading it returns the most recently received byte. A single mode bit makes the port a master or a slave.

As a master, the port makes its own serial clock from the bus clock. A two-bit rate field picks the divider. The port sends the transmit byte MSB first while it captures the byte coming back on its input line. As a slave, the port follows an external serial clock while an active-low select is held low. It loads its transmit byte when select falls and captures the byte arriving from the master.

Two flags report progress. The receiver-full flag sets when a byte arrives, and the transmitter-empty flag sets when the shifter takes the buffered byte. If a byte arrives while the previous one is still unread, an overflow flag sets. Receiver-full and overflow clear only through a status read that sees either flag set, followed by a read of the data register.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x20 (only transmitter-empty set), and sclk_o, mosi_o and miso_o are 0.
- R2: Control bit 7 enables the port, bit 6 selects master mode, and bits 1:0 select the rate. In master mode each serial clock phase lasts 1, 4, 16 or 64 bus cycles for rate 0, 1, 2 or 3, so the serial clock runs at the bus clock divided by 2, 8, 32 or 128. The serial clock idles low.
- R3: A master drives the transmit byte on mosi_o MSB first, stable across each rising serial clock edge, and samples miso_i on each rising edge. After the eighth falling edge, status bit 7 (receiver-full) is set and the data register (address 2) returns the captured byte.
- R4: Writing address 2 clears status bit 5 (transmitter-empty). The bit sets again when the shifter takes the byte, which is at the start of a master transfer or at the falling edge of select in slave mode.
- R5: Receiver-full clears only when a status read (address 1) that sees it set is followed by a data read. A data read with no such status read before it leaves the flag set.
- R6: If a byte completes while receiver-full is still set, status bit 6 (overflow) sets and the data register keeps the unread byte. Overflow clears through the same status-then-data read sequence.
- R7: With the enable bit set and the master bit clear, the port is a slave. It keeps sclk_o low, shifts only while sel_n_i is low, and assembles the byte from mosi_i MSB first on rising edges of sclk_i.
- R8: A slave receives correctly with serial clock phases as short as one bus cycle (half the bus rate, the fastest master rate), whatever the rate field holds.
- R9: A slave presents the buffered transmit byte on miso_o MSB first. The first bit is valid within three bus cycles after select falls, and each later bit is valid within three bus cycles after each falling edge of sclk_i.
- R10: Raising select before eight bits have arrived abandons the partial byte: receiver-full does not set, and the next selection starts again from bit 7.
- R11: While the enable bit is clear, writing the data register starts no transfer. Once the port is enabled in master mode, the buffered byte goes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives the flag-clearing side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| sel_n_i | input | 1 | Active-low slave select |
| mosi_o | output | 1 | Master serial data out |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |
| miso_i | input | 1 | Master serial data in |

## Verification
The bench goes after the flag-clearing order. It reads the data register with no status read before it, and it lets a second byte land on an unread one. A design that cleared receiver-full on any data read would lose the flag, and one that overwrote on overflow would return the newer byte. It drives a slave at one-bus-cycle clock phases with the slowest rate code set, which catches a slave that uses the rate divider or a synchronizer whose data path is not aligned with its clock path. It also drops select after three bits and checks that a disabled port ignores a data write, which exposes bit counters that are not reset and transfers that start without the enable bit.

// File: rtl/spi_port_pkg.sv
// Package: shared register addresses and bit positions for the SPI port.
// Assumes a data width of at least 8 so every status and control bit fits.
package spi_port_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2
    } reg_sel_e;

    localparam int CT_EN   = 7;
    localparam int CT_MST  = 6;
    localparam int ST_RXF  = 7;
    localparam int ST_OVF  = 6;
    localparam int ST_TXE  = 5;
    localparam int ST_BUSY = 0;
endpackage

// File: rtl/spi_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// All bits go through the same number of stages, so their relative timing
// is kept. RST_VAL gives the idle level of each bit.
module spi_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= d;
            end
        end else begin : g_next
            // Each later stage re-times the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_master_eng.sv
// Master shift engine: divides the bus clock into the serial clock and
// shifts one byte out MSB first while it samples the input line.
// Assumes start is pulsed only while the engine is idle. The serial clock
// idles low, data is sampled on rising edges and shifted on falling edges.
module spi_master_eng #(
    parameter int DATA_W = 8,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic [RATE_W-1:0] rate,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int MAX_HALF = 1 << (2 * ((1 << RATE_W) - 1));
    localparam int HC_W     = $clog2(MAX_HALF + 1);
    localparam int BIT_W    = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);
    localparam logic [HC_W-1:0]  ONE  = HC_W'(1);

    logic [HC_W-1:0]   hcnt;
    logic [HC_W-1:0]   half_m1;
    logic [BIT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] sh;
    logic              in_bit;
    logic              sclk_q;
    logic              busy_q;
    logic              tick;

    // Length of a serial clock phase minus one: 4^rate - 1.
    always_comb half_m1 = (ONE << {rate, 1'b0}) - ONE;

    assign tick    = busy_q && (hcnt >= half_m1);
    assign rx_byte = {sh[DATA_W-2:0], in_bit};
    assign done    = tick && sclk_q && (bitcnt == LAST);
    assign sclk    = sclk_q;
    assign mosi    = sh[DATA_W-1];
    assign busy    = busy_q;

    // Phase counter, clock toggling, sampling and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            hcnt   <= '0;
            bitcnt <= '0;
            sh     <= '0;
            in_bit <= 1'b0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            hcnt   <= '0;
            bitcnt <= '0;
            sh     <= tx_byte;
        end else if (busy_q) begin
            if (tick) begin
                hcnt   <= '0;
                sclk_q <= ~sclk_q;
                if (!sclk_q) begin
                    in_bit <= miso;
                end else begin
                    sh     <= rx_byte;
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == LAST) busy_q <= 1'b0;
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    // R2: the serial clock is low whenever no transfer is running.
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q);

    // R3: the byte completes on a falling edge and the engine goes idle.
    p_done_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!sclk_q && !busy_q));
endmodule

// File: rtl/spi_slave_eng.sv
// Slave shift engine: synchronizes the external serial clock, select and
// data to the bus clock, captures data on rising edges and advances the
// outgoing byte on falling edges. Assumes each serial clock phase lasts at
// least one bus cycle. Data goes through the same synchronizer as the
// clock, so the two stay aligned.
module spi_slave_eng #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sclk_pin,
    input  logic              sel_n_pin,
    input  logic              mosi_pin,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              miso,
    output logic              active,
    output logic              load,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

    logic [2:0]        pins_s;
    logic              sclk_s, sel_s, mosi_s;
    logic              prev_sclk, prev_sel;
    logic              rise, fall, sel_fall;
    logic [BIT_W-1:0]  cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              active_q;

    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk_pin, sel_n_pin, mosi_pin}),
        .q    (pins_s)
    );

    assign {sclk_s, sel_s, mosi_s} = pins_s;
    assign rise     = sclk_s && !prev_sclk;
    assign fall     = !sclk_s && prev_sclk;
    assign sel_fall = prev_sel && !sel_s;
    assign load     = en && sel_fall;
    assign rx_byte  = {rx_sh[DATA_W-2:0], mosi_s};
    assign done     = active_q && rise && (cnt == LAST);
    assign miso     = active_q && tx_sh[DATA_W-1];
    assign active   = active_q;

    // Edge-detect history of the synchronized clock and select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sclk <= 1'b0;
            prev_sel  <= 1'b1;
        end else begin
            prev_sclk <= sclk_s;
            prev_sel  <= sel_s;
        end
    end

    // Selection tracking, bit counting and both shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
        end else if (!en || sel_s) begin
            active_q <= 1'b0;
            cnt      <= '0;
        end else if (sel_fall) begin
            active_q <= 1'b1;
            cnt      <= '0;
            tx_sh    <= tx_byte;
        end else if (active_q) begin
            if (rise) begin
                rx_sh <= rx_byte;
                cnt   <= cnt + 1'b1;
            end
            if (fall) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
    end

    // R10: a deselected slave holds no partial bit count.
    p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (cnt == '0 && !active_q));

    // R9: taking the transmit byte always starts an active selection.
    p_load_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active_q);
endmodule

// File: rtl/spi_port_regs.sv
// Register file: control, transmit buffer, receive buffer and flags.
// Handles the read-sequence clearing of receiver-full and overflow.
// Assumes at most one completed byte per cycle and DATA_W of at least 8.
module spi_port_regs
    import spi_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              load,
    input  logic              done,
    input  logic [DATA_W-1:0] done_byte,
    input  logic              busy,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] tx_buf,
    output logic              tx_empty
);
    logic [DATA_W-1:0] rx_data;
    logic              rx_full;
    logic              ovf;
    logic              armed;
    logic              wr_ctrl, wr_data, rd_stat, rd_data, clr;
    logic [DATA_W-1:0] status;

    assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
    assign wr_data = bus_wr && (bus_addr == REG_DATA);
    assign rd_stat = bus_rd && (bus_addr == REG_STAT);
    assign rd_data = bus_rd && (bus_addr == REG_DATA);
    assign clr     = rd_data && armed;

    // Status word assembly.
    always_comb begin
        status          = '0;
        status[ST_RXF]  = rx_full;
        status[ST_OVF]  = ovf;
        status[ST_TXE]  = tx_empty;
        status[ST_BUSY] = busy;
    end

    // Read data mux.
    always_comb begin
        case (bus_addr)
            REG_CTRL: bus_rdata = ctrl;
            REG_STAT: bus_rdata = status;
            REG_DATA: bus_rdata = rx_data;
            default:  bus_rdata = '0;
        endcase
    end

    // Control and transmit buffer with the transmitter-empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            tx_buf   <= '0;
            tx_empty <= 1'b1;
        end else begin
            if (wr_ctrl) ctrl <= bus_wdata;
            if (wr_data) begin
                tx_buf   <= bus_wdata;
                tx_empty <= 1'b0;
            end else if (load) begin
                tx_empty <= 1'b1;
            end
        end
    end

    // Receive buffer, receiver-full, overflow and the clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            ovf     <= 1'b0;
            armed   <= 1'b0;
        end else begin
            if (rd_stat && (rx_full || ovf)) armed <= 1'b1;
            else if (clr)                    armed <= 1'b0;
            if (done) begin
                if (rx_full && !clr) begin
                    ovf <= 1'b1;
                end else begin
                    rx_data <= done_byte;
                    rx_full <= 1'b1;
                    if (clr) ovf <= 1'b0;
                end
            end else if (clr) begin
                rx_full <= 1'b0;
                ovf     <= 1'b0;
            end
        end
    end

    // R4: a data write always leaves the transmit buffer marked full.
    p_txe_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> !tx_empty);

    // R5: receiver-full survives unless the armed data read happens.
    p_rxf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !clr) |=> rx_full);

    // R6: a byte landing on an unread one flags overflow, keeps the old byte.
    p_ovf_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full && !clr) |=> (ovf && rx_data == $past(rx_data)));
endmodule

// File: rtl/spi_port.sv
// SPI port top: bus registers plus one master and one slave shift engine,
// selected by the master bit of the control register. Pins of the unused
// role are held low. Assumes the mode is not changed during a transfer.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int RATE_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk_o,
    input  logic              sclk_i,
    input  logic              sel_n_i,
    output logic              mosi_o,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              miso_i
);
    logic [DATA_W-1:0] ctrl, tx_buf, m_byte, s_byte, done_byte;
    logic              tx_empty, en, is_master;
    logic              m_start, m_sclk, m_mosi, m_busy, m_done;
    logic              s_en, s_miso, s_active, s_load, s_done;
    logic              load, done, busy;

    assign en        = ctrl[CT_EN];
    assign is_master = ctrl[CT_MST];
    assign m_start   = en && is_master && !tx_empty && !m_busy;
    assign s_en      = en && !is_master;
    assign load      = m_start || s_load;
    assign done      = m_done || s_done;
    assign done_byte = m_done ? m_byte : s_byte;
    assign busy      = m_busy || s_active;

    assign sclk_o = is_master && m_sclk;
    assign mosi_o = is_master && m_mosi;
    assign miso_o = !is_master && s_miso;

    spi_port_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .load     (load),
        .done     (done),
        .done_byte(done_byte),
        .busy     (busy),
        .ctrl     (ctrl),
        .tx_buf   (tx_buf),
        .tx_empty (tx_empty)
    );

    spi_master_eng #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_master (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (m_start),
        .tx_byte(tx_buf),
        .rate   (ctrl[RATE_W-1:0]),
        .miso   (miso_i),
        .sclk   (m_sclk),
        .mosi   (m_mosi),
        .busy   (m_busy),
        .done   (m_done),
        .rx_byte(m_byte)
    );

    spi_slave_eng #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (s_en),
        .sclk_pin (sclk_i),
        .sel_n_pin(sel_n_i),
        .mosi_pin (mosi_i),
        .tx_byte  (tx_buf),
        .miso     (s_miso),
        .active   (s_active),
        .load     (s_load),
        .done     (s_done),
        .rx_byte  (s_byte)
    );

    // R2: a rising serial clock at the pin only comes from a running master.
    p_sclk_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $past(m_busy));

    // R7: the slave engine completes bytes only in slave mode.
    p_slave_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_done |-> !is_master);
endmodule

// File: tb/spi_port_test.sv
module spi_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sclk_o, mosi_o, miso_o;
    logic       sclk_i = 1'b0;
    logic       sel_n_i = 1'b1;
    logic       mosi_i = 1'b0;
    logic       miso_i = 1'b0;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    spi_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk_o), .sclk_i(sclk_i), .sel_n_i(sel_n_i),
        .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o), .miso_i(miso_i)
    );

    // {rate, transmit byte, byte returned on miso_i}
    localparam logic [17:0] VEC [4] = '{
        {2'd0, 8'hA5, 8'h3C},
        {2'd1, 8'h81, 8'hC3},
        {2'd2, 8'h5A, 8'h96},
        {2'd3, 8'hFF, 8'h01}
    };

    task automatic do_check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic master_run(input logic [1:0] rate, input logic [7:0] tx,
                              input logic [7:0] pat, output logic [7:0] seen,
                              output int period);
        int  rises = 0;
        int  t = 0;
        int  last = 0;
        logic prev = 1'b0;
        seen = 8'h00;
        period = 0;
        bus_write(2'd0, 8'hC0 | {6'd0, rate});
        miso_i = pat[7];
        bus_write(2'd2, tx);
        while (!(rises == 8 && sclk_o == 1'b0) && t < 5000) begin
            @(negedge clk);
            t++;
            if (sclk_o && !prev) begin
                seen = {seen[6:0], mosi_o};
                if (rises == 1) period = t - last;
                last = t;
                rises++;
            end
            if (!sclk_o && prev && rises < 8) miso_i = pat[7 - rises];
            prev = sclk_o;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic slave_run(input logic [7:0] mo, input int half,
                             input int nbits, input bit chk_miso,
                             input logic [7:0] exp_miso, output bit saw_sclk);
        saw_sclk = 1'b0;
        @(negedge clk);
        sel_n_i = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi_i = mo[7 - i];
            repeat (half) @(negedge clk);
            if (sclk_o) saw_sclk = 1'b1;
            if (chk_miso) do_check("R9 miso bit", int'(miso_o), int'(exp_miso[7 - i]));
            sclk_i = 1'b1;
            repeat (half) @(negedge clk);
            if (sclk_o) saw_sclk = 1'b1;
            sclk_i = 1'b0;
        end
        repeat (4) @(negedge clk);
        sel_n_i = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, seen;
        int         period;
        bit         saw;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_check("R1 sclk_o", int'(sclk_o), 0);
        do_check("R1 mosi_o", int'(mosi_o), 0);
        do_check("R1 miso_o", int'(miso_o), 0);
        bus_read(2'd0, rd); do_check("R1 ctrl", rd, 8'h00);
        bus_read(2'd1, rd); do_check("R1 status", rd, 8'h20);

        // Table-driven master transfers over every rate (R2, R3, R5)
        for (int v = 0; v < 4; v++) begin
            logic [1:0] rate;
            logic [7:0] tx, pat;
            {rate, tx, pat} = VEC[v];
            master_run(rate, tx, pat, seen, period);
            do_check("R2 period", period, 2 << (2 * rate));
            do_check("R3 mosi byte", seen, tx);
            bus_read(2'd1, rd); do_check("R3 status full", rd, 8'hA0);
            bus_read(2'd2, rd); do_check("R3 rx byte", rd, pat);
            bus_read(2'd1, rd); do_check("R5 cleared", rd, 8'h20);
        end

        // R5: a data read without a prior status read leaves the flag set
        master_run(2'd0, 8'h12, 8'h34, seen, period);
        bus_read(2'd2, rd); do_check("R5 early data read", rd, 8'h34);
        bus_read(2'd1, rd); do_check("R5 still full", rd, 8'hA0);
        bus_read(2'd2, rd);
        bus_read(2'd1, rd); do_check("R5 after sequence", rd, 8'h20);

        // R6: overflow keeps the unread byte
        master_run(2'd0, 8'h11, 8'h22, seen, period);
        master_run(2'd0, 8'h33, 8'h44, seen, period);
        bus_read(2'd1, rd); do_check("R6 overflow status", rd, 8'hE0);
        bus_read(2'd2, rd); do_check("R6 kept byte", rd, 8'h22);
        bus_read(2'd1, rd); do_check("R6 cleared", rd, 8'h20);

        // R11: disabled port starts nothing; R4 write clears transmitter-empty
        begin
            int toggles = 0;
            bus_write(2'd0, 8'h40);
            bus_write(2'd2, 8'h77);
            miso_i = 1'b0;
            repeat (40) begin
                @(negedge clk);
                if (sclk_o) toggles++;
            end
            do_check("R11 no clock while disabled", toggles, 0);
            bus_read(2'd1, rd); do_check("R4 tx_empty cleared", rd, 8'h00);
            bus_write(2'd0, 8'hC0);
            repeat (60) @(negedge clk);
            bus_read(2'd1, rd); do_check("R11 sent after enable", rd, 8'hA0);
            bus_read(2'd2, rd); do_check("R11 rx byte", rd, 8'h00);
            bus_read(2'd1, rd);
        end

        // R7, R9: slave at a slow clock with miso checked
        bus_write(2'd0, 8'h80);
        bus_write(2'd2, 8'hC6);
        slave_run(8'h5B, 4, 8, 1'b1, 8'hC6, saw);
        do_check("R7 sclk_o quiet in slave", int'(saw), 0);
        bus_read(2'd1, rd); do_check("R7 slave full, R4 tx_empty set", rd, 8'hA0);
        bus_read(2'd2, rd); do_check("R7 slave rx byte", rd, 8'h5B);
        bus_read(2'd1, rd); do_check("R7 cleared", rd, 8'h20);

        // R8: one-cycle phases with the slowest rate code set
        bus_write(2'd0, 8'h83);
        slave_run(8'hE4, 1, 8, 1'b0, 8'h00, saw);
        bus_read(2'd1, rd); do_check("R8 fast slave full", rd, 8'hA0);
        bus_read(2'd2, rd); do_check("R8 fast slave byte", rd, 8'hE4);
        bus_read(2'd1, rd);

        // R10: partial byte abandoned, next selection restarts
        bus_write(2'd0, 8'h80);
        slave_run(8'hFF, 2, 3, 1'b0, 8'h00, saw);
        bus_read(2'd1, rd); do_check("R10 no full after abort", rd, 8'h20);
        slave_run(8'h39, 2, 8, 1'b0, 8'h00, saw);
        bus_read(2'd1, rd); do_check("R10 full after restart", rd, 8'hA0);
        bus_read(2'd2, rd); do_check("R10 restarted byte", rd, 8'h39);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule